// File: doc/BRIEF.md
# Tracking Servo Step Controller

This block is the digital heart of a tracking converter loop. Each clock it receives a signed error sample: the feedback quantity minus the present DAC output, in units of a quarter of one code step. Two windowed comparators with hysteresis turn that error into an up request or a down request. A pair of direction flags registers the requests on each rising edge. The flags then step a saturating output code by one per clock. That code drives an external DAC, which closes the loop.

When the enable input is low, both flags are forced inactive, so the code holds its value for as long as the block stays disabled. This gives track-and-hold behaviour with no droop. While disabled, the host may also preload the code. The host can read the code and a two-bit status that shows whether the loop is stepping up, stepping down or balanced.

Top module: `servo_tracker`

## Requirements
- R1: The up request becomes active when the error is greater than +2 (above +1/2 step). While the up flag is set, the request stays active for any error of +1 or more. It drops once the error falls below +1.
- R2: The down request becomes active when the error is below -2. While the down flag is set, the request stays active for any error of -1 or less. It drops once the error rises above -1.
- R3: With both flags clear, the loop is balanced and the code does not change. Starting from balance, an error in the range -2..+2 leaves the loop balanced.
- R4: The requests are captured into the flags on a rising edge, and the code moves one edge later, by exactly one per clock in the flagged direction. The code never changes by more than one between clocks, except through reset or preload.
- R5: While `en` is low, both flags are cleared on the next edge and the code keeps its last value indefinitely, whatever the error.
- R6: The code saturates. Stepping up at all ones leaves all ones, and stepping down at zero leaves zero; the code never wraps.
- R7: `status` encodes the registered flags as 2'b00 balanced, 2'b01 stepping up and 2'b10 stepping down. The value 2'b11 never occurs.
- R8: A synchronous active-high `rst` clears the code to zero and clears both flags.
- R9: When `preset_load` is high and `en` is low, the next edge loads `preset_val` into the code. When `en` is high, `preset_load` has no effect.
- R10: In a closed loop with a DAC of 4 error units per code, the code follows a stepped target at no more than one step per clock. It then settles within one code step of the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Loop enable; low freezes the code |
| preset_load | input | 1 | Load request for the code, honoured only while disabled |
| preset_val | input | CODE_W | Value loaded into the code |
| err_q | input | ERR_W | Signed error, feedback minus DAC, in quarter steps |
| code | output | CODE_W | Saturating output code to the DAC |
| status | output | 2 | 00 balanced, 01 up, 10 down |

## Verification
A table of open-loop error levels drives the loop through its decisions. Errors of ±3 and beyond show that the flags set. Errors of ±1 applied after a set, compared with the same values applied from balance, show that the hysteresis is in place. Errors of ±2 from balance probe the exact set thresholds. Disabled phases with a large error show that the code freezes, and that one more step is still taken on the edge where the disable is first seen. Directed runs then push the code against both rails. They also preload the code with the loop enabled and disabled. Finally, a closed loop with a model DAC makes rising and falling target steps, to confirm both the slew limit and the ±1 limit cycle around the target.

// File: rtl/servo_pkg.sv
package servo_pkg;

  typedef enum logic [1:0] {
    ST_BAL = 2'b00,
    ST_UP  = 2'b01,
    ST_DN  = 2'b10
  } servo_st_e;

  // Thresholds in quarter-step units, for the positive-going comparator.
  localparam int SET_Q = 2;   // set when error exceeds half a step
  localparam int REL_Q = 1;   // held while error is at least a quarter step

  // Hysteretic window decision on a sign-normalised error.
  function automatic logic window_req(input logic signed [31:0] e,
                                      input logic held);
    return (e > SET_Q) || (held && (e >= REL_Q));
  endfunction

  // Combine two requests; a conflict resolves to hold.
  function automatic logic [1:0] resolve_dir(input logic up, input logic dn);
    if (up && dn) return 2'b00;
    return {dn, up};
  endfunction

endpackage

// File: rtl/servo_window.sv
module servo_window #(
  parameter int ERR_W = 16,
  parameter bit DOWN  = 1'b0
) (
  input  logic [ERR_W-1:0] err,
  input  logic             held,
  output logic             req
);
  import servo_pkg::*;

  logic signed [ERR_W:0] e_ext;
  logic signed [31:0]    e_wide;

  generate
    if (DOWN) begin : g_neg
      assign e_ext = -$signed({err[ERR_W-1], err});
    end else begin : g_pos
      assign e_ext = $signed({err[ERR_W-1], err});
    end
  endgenerate

  assign e_wide = {{(31-ERR_W){e_ext[ERR_W]}}, e_ext};
  assign req    = window_req(e_wide, held);

endmodule

// File: rtl/servo_dir_reg.sv
module servo_dir_reg (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic req_up,
  input  logic req_dn,
  output logic up_f,
  output logic dn_f
);
  import servo_pkg::*;

  logic [1:0] dir_next;
  logic       conflict;

  assign conflict = req_up && req_dn;
  assign dir_next = en ? resolve_dir(req_up, req_dn) : 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_f <= 1'b0;
      dn_f <= 1'b0;
    end else begin
      up_f <= dir_next[0];
      dn_f <= dir_next[1];
    end
  end

endmodule

// File: rtl/servo_sat_counter.sv
module servo_sat_counter #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] load_val,
  input  logic              inc,
  input  logic              dec,
  output logic [CODE_W-1:0] code
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_MIN = '0;

  function automatic logic [CODE_W-1:0] step_code(input logic [CODE_W-1:0] c,
                                                  input logic up,
                                                  input logic dn);
    if (up && !dn) return (c == CODE_MAX) ? c : c + 1'b1;
    if (dn && !up) return (c == CODE_MIN) ? c : c - 1'b1;
    return c;
  endfunction

  logic at_top, at_floor;
  assign at_top   = (code == CODE_MAX);
  assign at_floor = (code == CODE_MIN);

  always_ff @(posedge clk) begin
    if (rst)       code <= '0;
    else if (load) code <= load_val;
    else           code <= step_code(code, inc, dec);
  end

endmodule

// File: rtl/servo_tracker.sv
module servo_tracker #(
  parameter int CODE_W = 8,
  parameter int ERR_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              preset_load,
  input  logic [CODE_W-1:0] preset_val,
  input  logic [ERR_W-1:0]  err_q,
  output logic [CODE_W-1:0] code,
  output logic [1:0]        status
);
  import servo_pkg::*;

  logic [1:0] req_v;
  logic [1:0] held_v;
  logic       up_f, dn_f;
  logic       load_en;

  assign held_v  = {dn_f, up_f};
  assign load_en = preset_load && !en;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_win
      servo_window #(.ERR_W(ERR_W), .DOWN(g == 1)) u_win (
        .err  (err_q),
        .held (held_v[g]),
        .req  (req_v[g])
      );
    end
  endgenerate

  servo_dir_reg u_dir (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .req_up (req_v[0]),
    .req_dn (req_v[1]),
    .up_f   (up_f),
    .dn_f   (dn_f)
  );

  servo_sat_counter #(.CODE_W(CODE_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (load_en),
    .load_val (preset_val),
    .inc      (up_f),
    .dec      (dn_f),
    .code     (code)
  );

  always_comb begin
    if (up_f && !dn_f)      status = ST_UP;
    else if (dn_f && !up_f) status = ST_DN;
    else                    status = ST_BAL;
  end

endmodule

// File: rtl/servo_tracker_chk.sv
module servo_tracker_chk #(
  parameter int CODE_W = 8,
  parameter int ERR_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              preset_load,
  input logic [CODE_W-1:0] preset_val,
  input logic [ERR_W-1:0]  err_q,
  input logic [CODE_W-1:0] code,
  input logic [1:0]        status
);
  localparam logic [CODE_W-1:0] CMAX = {CODE_W{1'b1}};

  logic signed [ERR_W-1:0] e;
  logic                    ld;
  logic [CODE_W-1:0]       delta;
  assign e  = $signed(err_q);
  assign ld = preset_load && !en;

  always_ff @(posedge clk) begin
    if (rst) delta <= '0;
    else     delta <= code;
  end

  AST_UP_SET: assert property (@(posedge clk) disable iff (rst)
    (en && e > 2) |=> status == 2'b01); // R1
  AST_UP_REL: assert property (@(posedge clk) disable iff (rst)
    (en && e < 1 && e > -3) |=> status != 2'b01); // R1
  AST_DN_SET: assert property (@(posedge clk) disable iff (rst)
    (en && e < -2) |=> status == 2'b10); // R2
  AST_DN_REL: assert property (@(posedge clk) disable iff (rst)
    (en && e > -1 && e < 3) |=> status != 2'b10); // R2
  AST_BAL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (status == 2'b00 && !ld) |=> $stable(code)); // R3
  AST_UP_MOVE: assert property (@(posedge clk) disable iff (rst)
    (status == 2'b01 && code != CMAX && !ld) |=> code == $past(code) + 1'b1); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    !ld |=> (code == $past(code) || code == $past(code) + 1'b1 || code == $past(code) - 1'b1)); // R4
  AST_DIS_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |=> status == 2'b00); // R5
  AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (rst)
    (code == CMAX && status == 2'b01 && !ld) |=> code == CMAX); // R6
  AST_NO_WRAP_BOT: assert property (@(posedge clk) disable iff (rst)
    (code == '0 && status == 2'b10 && !ld) |=> code == '0); // R6
  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (rst)
    status != 2'b11); // R7
  AST_RESET: assert property (@(posedge clk)
    rst |=> (code == '0 && status == 2'b00)); // R8
  AST_PRESET: assert property (@(posedge clk) disable iff (rst)
    ld |=> code == $past(preset_val)); // R9

endmodule

bind servo_tracker servo_tracker_chk #(.CODE_W(CODE_W), .ERR_W(ERR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .en          (en),
  .preset_load (preset_load),
  .preset_val  (preset_val),
  .err_q       (err_q),
  .code        (code),
  .status      (status)
);

// File: tb/tb_servo_tracker.sv
module tb_servo_tracker;
  localparam int CODE_W = 8;
  localparam int ERR_W  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              en = 1'b0;
  logic              preset_load = 1'b0;
  logic [CODE_W-1:0] preset_val = '0;
  logic [ERR_W-1:0]  err_q = '0;
  logic [CODE_W-1:0] code;
  logic [1:0]        status;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk; // 50 MHz

  servo_tracker #(.CODE_W(CODE_W), .ERR_W(ERR_W)) dut (
    .clk(clk), .rst(rst), .en(en), .preset_load(preset_load),
    .preset_val(preset_val), .err_q(err_q), .code(code), .status(status)
  );

  typedef struct packed {
    logic               en;
    logic signed [15:0] err;
    logic [7:0]         n;
    logic [7:0]         code;
    logic [1:0]         st;
  } vec_t;

  // status: 0 balanced, 1 up, 2 down
  localparam vec_t TBL [16] = '{
    '{1'b1,  16'sd0, 8'd2, 8'd0, 2'd0},  // R3 idle
    '{1'b1,  16'sd3, 8'd5, 8'd4, 2'd1},  // R1 set, R4 one-edge lag
    '{1'b1,  16'sd1, 8'd3, 8'd7, 2'd1},  // R1 hysteresis held
    '{1'b1,  16'sd0, 8'd3, 8'd8, 2'd0},  // R1 release
    '{1'b1,  16'sd2, 8'd3, 8'd8, 2'd0},  // R3 +2 from balance
    '{1'b1,  16'sd1, 8'd2, 8'd8, 2'd0},  // R1 +1 does not set
    '{1'b1, -16'sd3, 8'd4, 8'd5, 2'd2},  // R2 set
    '{1'b1, -16'sd1, 8'd2, 8'd3, 2'd2},  // R2 hysteresis held
    '{1'b1,  16'sd0, 8'd1, 8'd2, 2'd0},  // R2 release
    '{1'b1, -16'sd2, 8'd3, 8'd2, 2'd0},  // R3 -2 from balance
    '{1'b0, -16'sd5, 8'd4, 8'd2, 2'd0},  // R5 disabled
    '{1'b1, -16'sd5, 8'd6, 8'd0, 2'd2},  // R6 floor
    '{1'b1,  16'sd0, 8'd1, 8'd0, 2'd0},  // R6 floor no wrap
    '{1'b1,  16'sd9, 8'd3, 8'd2, 2'd1},  // R4 stepping
    '{1'b0,  16'sd9, 8'd3, 8'd3, 2'd0},  // R5 freeze after last step
    '{1'b0,  16'sd9, 8'd5, 8'd3, 2'd0}   // R5 indefinite hold
  };

  function automatic string tbl_req(int i);
    case (i)
      0, 4, 9:    return "R3";
      1, 2, 3, 5: return "R1";
      6, 7, 8:    return "R2";
      10, 14, 15: return "R5";
      11, 12:     return "R6";
      default:    return "R4";
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic preload(int v);
    en = 1'b0;
    preset_load = 1'b1;
    preset_val = CODE_W'(v);
    @(posedge clk);
    @(negedge clk);
    preset_load = 1'b0;
  endtask

  task automatic closed_loop(int target_q, int cycles, int settle_code);
    int prev;
    int d;
    prev = int'(code);
    err_q = ERR_W'(target_q - 4 * int'(code));
    en = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      d = int'(code) - prev;
      if (d < 0) d = -d;
      chk("R10 step", (d <= 1) ? 1 : 0, 1);
      prev = int'(code);
      err_q = ERR_W'(target_q - 4 * int'(code));
      if (i >= cycles - 20) begin
        d = int'(code) - settle_code;
        if (d < 0) d = -d;
        chk("R10 settle", (d <= 1) ? 1 : 0, 1);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 code", int'(code), 0);
    chk("R8 status", int'(status), 0);
    rst = 1'b0;

    for (int i = 0; i < 16; i++) begin
      en = TBL[i].en;
      err_q = ERR_W'(TBL[i].err);
      repeat (int'(TBL[i].n)) @(posedge clk);
      @(negedge clk);
      chk(tbl_req(i), int'(code), int'(TBL[i].code));
      chk(tbl_req(i), int'(status), int'(TBL[i].st));
    end

    // R9 preload while disabled
    err_q = '0;
    preload(200);
    chk("R9 load", int'(code), 200);
    // R9 ignored while enabled
    en = 1'b1;
    preset_load = 1'b1;
    preset_val = 8'd50;
    repeat (3) @(posedge clk);
    @(negedge clk);
    preset_load = 1'b0;
    chk("R9 ignored", int'(code), 200);

    // R6 top rail
    preload(250);
    en = 1'b1;
    err_q = ERR_W'(9);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R6 top", int'(code), 255);
    chk("R6 top status", int'(status), 1);

    // R10 closed loop, rising then falling target
    err_q = '0;
    preload(0);
    closed_loop(400, 150, 100);
    closed_loop(200, 100, 50);

    // R8 reset mid-run
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R8 mid code", int'(code), 0);
    chk("R8 mid status", int'(status), 0);

    finish_run();
  end

endmodule